// File: doc/BRIEF.md
# Reservation Station Pool with Tag Wakeup

This block is a small pool of reservation-station entries placed in front of a single functional unit, such as an add/subtract unit, in a dynamically scheduled pipeline. Issue logic hands it an operation code, a destination tag and two source operands. Each source operand arrives either as a ready value or as the tag of the producer that will compute it. Entries that are still waiting watch a single result broadcast bus. When the tag on the bus matches a pending operand, the entry latches the value from the bus.

Every cycle, at most one entry whose operands are both present is sent to the execution unit, the oldest first. The entry stays occupied until the result for its destination tag appears on the broadcast bus, and it is then released. A full indication lets the issue stage stall when no entry is free. A flush input empties the pool. The execution datapath, the register file and the rename table sit outside this block.

Top module: `rs_pool`

## Requirements
- R1: After reset, `full_o` is 0 and `disp_valid_o` is 0.
- R2: An instruction is accepted when `issue_valid_i` is 1, `full_o` is 0 and `flush_i` is 0. `full_o` is 1 exactly when all 4 entries are occupied. An instruction offered while `full_o` is 1 is dropped and is never dispatched.
- R3: For each source operand, a tag of 0 means the value field carries the operand. A nonzero tag (1 to 7, 3 bits) names the producer still to deliver it.
- R4: While an operand is pending, a broadcast with `bc_valid_i` = 1 and `bc_tag_i` equal to its tag loads `bc_val_i` into it. The entry can be dispatched in the cycle after that broadcast.
- R5: If an instruction is accepted in the same cycle as a broadcast whose tag matches one of its nonzero source tags, the entry stores the broadcast value for that operand and does not wait for that tag again.
- R6: `disp_valid_o` is 1 only for an occupied, not-yet-dispatched entry whose two operands are both present. It presents that entry's op, operand values and destination tag. Each entry is dispatched once.
- R7: When several entries are ready, the one accepted earliest is dispatched first, one per cycle.
- R8: A dispatched entry is released on the clock edge at which a broadcast carries its destination tag. Its slot can be reused from the next cycle.
- R9: `flush_i` empties every entry at the next edge. An issue offered in the flush cycle is not accepted.
- R10: An instruction accepted with both operands present is dispatched in the cycle right after its acceptance, provided no older entry is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty all entries |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | 3 | Operation code |
| issue_s1_tag_i | input | 3 | Source 1 producer tag, 0 = value present |
| issue_s1_val_i | input | 16 | Source 1 value |
| issue_s2_tag_i | input | 3 | Source 2 producer tag, 0 = value present |
| issue_s2_val_i | input | 16 | Source 2 value |
| issue_dst_i | input | 3 | Destination tag |
| full_o | output | 1 | All entries occupied |
| bc_valid_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | 3 | Result broadcast tag |
| bc_val_i | input | 16 | Result broadcast value |
| disp_valid_o | output | 1 | Dispatch to the execution unit |
| disp_op_o | output | 3 | Dispatched op |
| disp_a_o | output | 16 | Dispatched operand 1 |
| disp_b_o | output | 16 | Dispatched operand 2 |
| disp_dst_o | output | 3 | Dispatched destination tag |

## Verification
A corrupted operand tag or value shows up in one of two ways. Either a dispatch is missing, or wrong operand data appears on the dispatch port in the cycle the entry becomes eligible, one cycle after the capturing broadcast. A corrupted occupancy or dispatched flag shows up in the cycle of the corruption, as a wrong `full_o` or as a repeated or missing dispatch. A corrupted age order shows up only when two or more entries are ready together. It then appears as a wrong destination tag on `disp_dst_o` in that same cycle. The reference model compares `full_o` and the full dispatch word in every cycle, so the first cycle in which any of these effects appears is reported.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_ENTRIES = 4;
  localparam int unsigned RS_TAG_W   = 3;
  localparam int unsigned RS_DATA_W  = 16;
  localparam int unsigned RS_OP_W    = 3;
  localparam int unsigned RS_NSRC    = 2;
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int unsigned N_ENT = 4
) (
  input  logic [N_ENT-1:0] busy_i,
  output logic [N_ENT-1:0] alloc_oh_o,
  output logic             full_o
);
  // lowest-index free slot
  always_comb begin
    alloc_oh_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        alloc_oh_o    = '0;
        alloc_oh_o[i] = 1'b1;
      end
    end
  end

  assign full_o = &busy_i;
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int unsigned N_ENT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] alloc_i,
  input  logic [N_ENT-1:0] ready_i,
  output logic [N_ENT-1:0] grant_o
);
  // older[i][j] = entry i was accepted before entry j
  logic [N_ENT-1:0] older [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_row
    logic [N_ENT-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          row_q <= '0;
      else if (alloc_i[i])  row_q <= '0;
      else                  row_q <= row_q | alloc_i;
    end
    assign older[i] = row_q;
  end

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N_ENT; j++) begin
        if (ready_i[j] && older[j][i]) blocked = 1'b1;
      end
      grant_o[i] = ready_i[i] && !blocked;
    end
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 3,
  parameter int unsigned NSRC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_i,
  input  logic              grant_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [TAG_W-1:0]  src_tag_i [NSRC],
  input  logic [DATA_W-1:0] src_val_i [NSRC],
  input  logic [TAG_W-1:0]  dst_i,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] val_o [NSRC],
  output logic [TAG_W-1:0]  dst_o
);
  logic             busy_q, sent_q;
  logic [OP_W-1:0]  op_q;
  logic [TAG_W-1:0] dst_q;
  logic [NSRC-1:0]  have;
  logic             free_hit;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] val_q;
    logic              hit_new, hit_old;
    assign hit_new = bc_valid_i && (src_tag_i[k] != '0) && (bc_tag_i == src_tag_i[k]);
    assign hit_old = bc_valid_i && (tag_q != '0) && (bc_tag_i == tag_q);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        val_q <= '0;
      end else if (alloc_i) begin
        tag_q <= hit_new ? '0 : src_tag_i[k];
        val_q <= hit_new ? bc_val_i : src_val_i[k];
      end else if (busy_q && hit_old) begin
        tag_q <= '0;
        val_q <= bc_val_i;
      end
    end
    assign have[k]  = (tag_q == '0);
    assign val_o[k] = val_q;
  end

  assign free_hit = busy_q && sent_q && bc_valid_i && (bc_tag_i == dst_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      op_q   <= '0;
      dst_q  <= '0;
    end else if (flush_i) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      sent_q <= 1'b0;
      op_q   <= op_i;
      dst_q  <= dst_i;
    end else if (free_hit) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
    end else if (grant_i) begin
      sent_q <= 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !sent_q && (&have);
  assign op_o    = op_q;
  assign dst_o   = dst_q;
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int unsigned N_ENT  = RS_ENTRIES,
  parameter int unsigned TAG_W  = RS_TAG_W,
  parameter int unsigned DATA_W = RS_DATA_W,
  parameter int unsigned OP_W   = RS_OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              issue_valid_i,
  input  logic [OP_W-1:0]   issue_op_i,
  input  logic [TAG_W-1:0]  issue_s1_tag_i,
  input  logic [DATA_W-1:0] issue_s1_val_i,
  input  logic [TAG_W-1:0]  issue_s2_tag_i,
  input  logic [DATA_W-1:0] issue_s2_val_i,
  input  logic [TAG_W-1:0]  issue_dst_i,
  output logic              full_o,
  input  logic              bc_valid_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  output logic              disp_valid_o,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_a_o,
  output logic [DATA_W-1:0] disp_b_o,
  output logic [TAG_W-1:0]  disp_dst_o
);
  localparam int unsigned NSRC = RS_NSRC;

  logic [N_ENT-1:0]  busy_vec, ready_vec, alloc_oh, alloc_vec, grant_oh;
  logic              accept;
  logic [TAG_W-1:0]  src_tag [NSRC];
  logic [DATA_W-1:0] src_val [NSRC];
  logic [OP_W-1:0]   ent_op  [N_ENT];
  logic [TAG_W-1:0]  ent_dst [N_ENT];
  logic [DATA_W-1:0] ent_a   [N_ENT];
  logic [DATA_W-1:0] ent_b   [N_ENT];

  assign src_tag[0] = issue_s1_tag_i;
  assign src_tag[1] = issue_s2_tag_i;
  assign src_val[0] = issue_s1_val_i;
  assign src_val[1] = issue_s2_val_i;

  rs_alloc #(.N_ENT(N_ENT)) u_alloc (
    .busy_i     (busy_vec),
    .alloc_oh_o (alloc_oh),
    .full_o     (full_o)
  );

  assign accept    = issue_valid_i && !full_o && !flush_i;
  assign alloc_vec = accept ? alloc_oh : '0;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [DATA_W-1:0] vals [NSRC];
    rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .NSRC(NSRC)) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .alloc_i    (alloc_vec[i]),
      .grant_i    (grant_oh[i]),
      .op_i       (issue_op_i),
      .src_tag_i  (src_tag),
      .src_val_i  (src_val),
      .dst_i      (issue_dst_i),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_val_i   (bc_val_i),
      .busy_o     (busy_vec[i]),
      .ready_o    (ready_vec[i]),
      .op_o       (ent_op[i]),
      .val_o      (vals),
      .dst_o      (ent_dst[i])
    );
    assign ent_a[i] = vals[0];
    assign ent_b[i] = vals[1];
  end

  rs_select #(.N_ENT(N_ENT)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc_vec),
    .ready_i (ready_vec),
    .grant_o (grant_oh)
  );

  always_comb begin
    disp_op_o  = '0;
    disp_a_o   = '0;
    disp_b_o   = '0;
    disp_dst_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant_oh[i]) begin
        disp_op_o  = disp_op_o  | ent_op[i];
        disp_a_o   = disp_a_o   | ent_a[i];
        disp_b_o   = disp_b_o   | ent_b[i];
        disp_dst_o = disp_dst_o | ent_dst[i];
      end
    end
  end

  assign disp_valid_o = |grant_oh;
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int unsigned N_ENT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             issue_valid_i,
  input logic             bc_valid_i,
  input logic             full_o,
  input logic             disp_valid_o,
  input logic [N_ENT-1:0] busy_vec,
  input logic [N_ENT-1:0] grant_oh
);
  // R6
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_oh));

  // R6
  grant_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_oh & ~busy_vec) == '0);

  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (busy_vec == '0) && !disp_valid_o);

  // R2
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !bc_valid_i && !flush_i) |=> full_o);

  // R10
  empty_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !flush_i && busy_vec == '0) |=> $countones(busy_vec) == 1);
endmodule

bind rs_pool rs_pool_chk #(.N_ENT(N_ENT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .issue_valid_i (issue_valid_i),
  .bc_valid_i    (bc_valid_i),
  .full_o        (full_o),
  .disp_valid_o  (disp_valid_o),
  .busy_vec      (busy_vec),
  .grant_oh      (grant_oh)
);

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic [2:0]  issue_op_i = '0;
  logic [2:0]  issue_s1_tag_i = '0;
  logic [15:0] issue_s1_val_i = '0;
  logic [2:0]  issue_s2_tag_i = '0;
  logic [15:0] issue_s2_val_i = '0;
  logic [2:0]  issue_dst_i = '0;
  logic        full_o;
  logic        bc_valid_i = 1'b0;
  logic [2:0]  bc_tag_i = '0;
  logic [15:0] bc_val_i = '0;
  logic        disp_valid_o;
  logic [2:0]  disp_op_o;
  logic [15:0] disp_a_o, disp_b_o;
  logic [2:0]  disp_dst_o;

  always #5 clk_i = ~clk_i;

  rs_pool dut (
    .clk_i, .rst_ni, .flush_i, .issue_valid_i, .issue_op_i,
    .issue_s1_tag_i, .issue_s1_val_i, .issue_s2_tag_i, .issue_s2_val_i,
    .issue_dst_i, .full_o, .bc_valid_i, .bc_tag_i, .bc_val_i,
    .disp_valid_o, .disp_op_o, .disp_a_o, .disp_b_o, .disp_dst_o
  );

  typedef struct {
    logic [2:0]  op;
    logic [15:0] a, b;
    logic [2:0]  ta, tb, dst;
    bit          sent;
  } ent_t;

  ent_t  q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R1";

  function automatic int pick();
    for (int i = 0; i < q.size(); i++)
      if (!q[i].sent && q[i].ta == 0 && q[i].tb == 0) return i;
    return -1;
  endfunction

  task automatic compare();
    int p;
    bit ev;
    p  = pick();
    ev = (p >= 0);
    n_cmp++;
    if (full_o !== (q.size() == 4)) begin
      n_bad++;
      $display("FAIL %s full_o act=%0b exp=%0b", req, full_o, q.size() == 4);
    end
    n_cmp++;
    if (disp_valid_o !== ev) begin
      n_bad++;
      $display("FAIL %s disp_valid act=%0b exp=%0b", req, disp_valid_o, ev);
    end else if (ev) begin
      n_cmp++;
      if (disp_op_o !== q[p].op || disp_a_o !== q[p].a ||
          disp_b_o !== q[p].b || disp_dst_o !== q[p].dst) begin
        n_bad++;
        $display("FAIL %s dispatch act=%0d/%0h/%0h/%0d exp=%0d/%0h/%0h/%0d", req,
                 disp_op_o, disp_a_o, disp_b_o, disp_dst_o,
                 q[p].op, q[p].a, q[p].b, q[p].dst);
      end
    end
  endtask

  task automatic model_step();
    ent_t nq[$];
    ent_t e;
    int   p;
    bit   hit;
    if (flush_i) begin
      q.delete();
      return;
    end
    p = pick();
    for (int i = 0; i < q.size(); i++) begin
      e = q[i];
      if (e.sent && bc_valid_i && bc_tag_i == e.dst) continue;
      if (i == p) e.sent = 1;
      if (bc_valid_i && e.ta != 0 && e.ta == bc_tag_i) begin e.ta = 0; e.a = bc_val_i; end
      if (bc_valid_i && e.tb != 0 && e.tb == bc_tag_i) begin e.tb = 0; e.b = bc_val_i; end
      nq.push_back(e);
    end
    if (issue_valid_i && q.size() < 4) begin
      e.op = issue_op_i; e.a = issue_s1_val_i; e.b = issue_s2_val_i;
      e.ta = issue_s1_tag_i; e.tb = issue_s2_tag_i; e.dst = issue_dst_i; e.sent = 0;
      hit = bc_valid_i && e.ta != 0 && e.ta == bc_tag_i;
      if (hit) begin e.ta = 0; e.a = bc_val_i; end
      hit = bc_valid_i && e.tb != 0 && e.tb == bc_tag_i;
      if (hit) begin e.tb = 0; e.b = bc_val_i; end
      nq.push_back(e);
    end
    q = nq;
  endtask

  task automatic cyc(input bit iv, input int op, input int t1, input int v1,
                     input int t2, input int v2, input int dst,
                     input bit bv, input int bt, input int bval, input bit fl);
    compare();
    issue_valid_i  = iv;
    issue_op_i     = 3'(op);
    issue_s1_tag_i = 3'(t1);
    issue_s1_val_i = 16'(v1);
    issue_s2_tag_i = 3'(t2);
    issue_s2_val_i = 16'(v2);
    issue_dst_i    = 3'(dst);
    bc_valid_i     = bv;
    bc_tag_i       = 3'(bt);
    bc_val_i       = 16'(bval);
    flush_i        = fl;
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic bcast(input int t, input int v);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, t, v, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: idle pool after reset
    req = "R1";
    idle(); idle();
    // R10 and R3: values present (tag 0), dispatch in the following cycle
    req = "R10";
    cyc(1, 1, 0, 16'h11, 0, 16'h22, 1, 0, 0, 0, 0);
    idle();
    bcast(1, 0);
    idle();
    // R4: pending operand captured from the broadcast
    req = "R4";
    cyc(1, 2, 5, 0, 0, 7, 2, 0, 0, 0, 0);
    idle(); idle();
    bcast(5, 16'h99);
    idle();
    bcast(2, 0);
    // R5: issue and matching broadcast in the same cycle
    req = "R5";
    cyc(1, 3, 0, 1, 6, 0, 3, 1, 6, 16'h55, 0);
    idle();
    bcast(3, 0);
    idle();
    // R2: fill the pool, then an issue offered while full is dropped
    req = "R2";
    cyc(1, 4, 4, 0, 0, 10, 1, 0, 0, 0, 0);
    cyc(1, 5, 4, 0, 0, 20, 2, 0, 0, 0, 0);
    cyc(1, 6, 4, 0, 0, 30, 3, 0, 0, 0, 0);
    cyc(1, 7, 4, 0, 0, 40, 5, 0, 0, 0, 0);
    cyc(1, 1, 0, 1, 0, 2, 7, 0, 0, 0, 0);
    idle();
    // R7: all become ready together, dispatched oldest first
    req = "R7";
    bcast(4, 16'h40);
    idle(); idle(); idle(); idle();
    // R8: release via destination tag, slot reused
    req = "R8";
    bcast(1, 0);
    cyc(1, 2, 0, 3, 0, 4, 6, 0, 0, 0, 0);
    idle();
    // R9: flush with a simultaneous issue
    req = "R9";
    cyc(1, 3, 0, 5, 0, 6, 4, 0, 0, 0, 1);
    idle(); idle();
    // R6: mixed random traffic
    req = "R6";
    for (int n = 0; n < 600; n++) begin
      int t1, t2;
      t1 = ($urandom % 2) ? 0 : 1 + $urandom % 7;
      t2 = ($urandom % 2) ? 0 : 1 + $urandom % 7;
      cyc($urandom % 2, $urandom % 8, t1, $urandom % 65536, t2, $urandom % 65536,
          1 + $urandom % 7, ($urandom % 2) == 1, 1 + $urandom % 7, $urandom % 65536,
          ($urandom % 60) == 0);
    end
    compare();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule